// File: doc/BRIEF.md
# Audio Serial Bit-Clock Generator

This block produces the bit clock of an audio serial port from two inputs only: the master clock, which also clocks all of its logic, and the frame (word-select) clock. It measures how many master-clock cycles each frame-clock period lasts and maps that count to one of ten supported master-to-frame ratios. The detected ratio and a data-format select then fix the number of bit-clock periods per frame and the master-clock divide value.

The bit clock is produced as a registered level plus single-cycle rising-edge and falling-edge strobes, all in the master-clock domain, so logic downstream needs no second clock. The divider restarts on every frame-clock edge, so a bit-clock falling strobe always lines up with a frame-clock transition. A lock flag reports when the ratio is trusted. While the lock flag is low, every bit-clock output stays low.

Top module: `bclk_gen`

## Requirements
- R1: After reset `locked_o` is 0, `ratio_code_o` is 15 (no ratio), and `bclk_o`, `bclk_rise_o` and `bclk_fall_o` are 0.
- R2: Ratio codes are 0:64, 1:96, 2:128, 3:192, 4:256, 5:384, 6:512, 7:768, 8:1024, 9:1152 master cycles per frame. The first frame-clock rising edge after reset only starts the measurement. Lock is declared at a rising edge whose measured period equals the previous period and is supported. `ratio_code_o` then shows that code and does not change while lock holds.
- R3: For ratio codes 1, 3, 5 and 7 (96, 192, 384, 768) there are 48 bit-clock periods per frame in both formats.
- R4: For ratio code 9 (1152) there are 72 bit-clock periods per frame in both formats.
- R5: With `fmt_lj_i` = 0 (I2S) and ratio codes 0, 2, 4, 6 or 8, there are 32 bit-clock periods per frame.
- R6: With `fmt_lj_i` = 1 (left-justified) and ratio codes 0, 2, 4, 6 or 8, there are 64 bit-clock periods per frame. When this gives a divide of 1 (ratio 64), both strobes are high in every locked cycle and `bclk_o` stays high.
- R7: While locked, every frame-clock transition gives a `bclk_fall_o` strobe, with `bclk_o` low when the divide is 2 or more. The strobe appears in the third master-clock cycle after the edge on which the new frame-clock level is first sampled. The first strobe after lock coincides with `locked_o` rising.
- R8: A measured period that matches no supported ratio clears `locked_o`, sets `ratio_code_o` to 15 and holds all bit-clock outputs low.
- R9: If no frame-clock rising edge arrives for 1152 master cycles, lock is cleared.
- R10: When the ratio changes, lock drops at the first rising edge that measures the new period. It returns at the next rising edge that measures the same new period.
- R11: For divides of 2 or more, `bclk_rise_o` comes half a bit period (divide/2 cycles) after each falling strobe. `bclk_o` is high from a rising strobe until the next falling strobe, and it only goes high on a rising strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Active-low reset |
| frame_clk_i | input | 1 | Frame clock, asynchronous to the sampling point |
| fmt_lj_i | input | 1 | 0 = I2S, 1 = left-justified |
| bclk_o | output | 1 | Bit-clock level |
| bclk_rise_o | output | 1 | One-cycle strobe at each bit-clock rising edge |
| bclk_fall_o | output | 1 | One-cycle strobe at each bit-clock falling edge |
| ratio_code_o | output | 4 | Detected ratio code, 15 when not locked |
| locked_o | output | 1 | Ratio detected and stable |

## Verification
The checker assumes the frame-clock period is an exact whole number of master cycles with equal high and low halves. It also assumes the format select does not change while lock holds, because a mid-frame change of divide would break the half-period relation between the strobes. The bench toggles the frame clock only on master-clock falling edges, uses exactly ratio/2 cycles per half, and changes the format only under reset. The bench also covers ratio changes, unsupported periods and a stopped frame clock, so that the lock-drop and quiet-output rules are exercised and not only the steady state.

// File: rtl/bclk_gen_pkg.sv
`timescale 1ns/1ps
package bclk_gen_pkg;

    localparam int unsigned NUM_RATIOS = 10;
    localparam int unsigned CODE_W     = 4;
    localparam int unsigned RATIO_MAX  = 1152;

    typedef logic [CODE_W-1:0] rcode_t;
    localparam rcode_t CODE_NONE = 4'hF;

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } fmt_e;

    // master cycles per frame for a ratio code, 0 for an unused code
    function automatic int unsigned ratio_of(input rcode_t c);
        int unsigned r;
        if (c == 4'd8)      r = 1024;
        else if (c == 4'd9) r = 1152;
        else if (c > 4'd9)  r = 0;
        else                r = (c[0] ? 32'd96 : 32'd64) << c[3:1];
        return r;
    endfunction

    // map a measured period onto a ratio code
    function automatic rcode_t classify(input logic [15:0] n);
        rcode_t r;
        r = CODE_NONE;
        for (int i = 0; i < int'(NUM_RATIOS); i++) begin
            if (32'(n) == ratio_of(rcode_t'(i))) r = rcode_t'(i);
        end
        return r;
    endfunction

    // master cycles per bit-clock period
    function automatic int unsigned div_of(input rcode_t c, input fmt_e f);
        int unsigned d;
        if (c == 4'd9)       d = 16;                  // 1152 / 72
        else if (c > 4'd9)   d = 1;
        else if (c[0])       d = 32'd2 << c[3:1];     // 48 per frame
        else if (f == FMT_LJ) d = 32'd1 << c[3:1];    // 64 per frame
        else                 d = 32'd2 << c[3:1];     // 32 per frame
        return d;
    endfunction

endpackage

// File: rtl/bclk_sync.sv
`timescale 1ns/1ps
module bclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic edge_o,
    output logic rise_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d[0] = async_i;
        for (int i = 1; i <= LAST; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign edge_o = chain_q[LAST-1] ^ chain_q[LAST];
    assign rise_o = chain_q[LAST-1] & ~chain_q[LAST];

endmodule

// File: rtl/bclk_period_meter.sv
`timescale 1ns/1ps
module bclk_period_meter
    import bclk_gen_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   rise_i,
    output logic   lock_next_o,
    output rcode_t code_next_o,
    output logic   locked_o,
    output rcode_t code_o
);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(RATIO_MAX);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             seen;
        rcode_t           prev;
        logic             locked;
        rcode_t           code;
    } meter_st_t;

    meter_st_t st_d, st_q;
    rcode_t    meas;

    always_comb begin
        st_d = st_q;
        meas = classify(16'(st_q.cnt) + 16'd1);
        if (rise_i) begin
            st_d.cnt = '0;
            if (!st_q.seen) begin
                st_d.seen = 1'b1;
            end else if (meas == CODE_NONE) begin
                st_d.locked = 1'b0;
                st_d.prev   = CODE_NONE;
            end else begin
                st_d.locked = (meas == st_q.prev);
                st_d.prev   = meas;
            end
        end else if (st_q.cnt < CNT_LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.locked = 1'b0;
            st_d.prev   = CODE_NONE;
        end
        st_d.code = st_d.locked ? st_d.prev : CODE_NONE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt    <= '0;
            st_q.seen   <= 1'b0;
            st_q.prev   <= CODE_NONE;
            st_q.locked <= 1'b0;
            st_q.code   <= CODE_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_next_o = st_d.locked;
    assign code_next_o = st_d.code;
    assign locked_o    = st_q.locked;
    assign code_o      = st_q.code;

endmodule

// File: rtl/bclk_divider.sv
`timescale 1ns/1ps
module bclk_divider
    import bclk_gen_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   edge_i,
    input  logic   en_i,
    input  rcode_t code_i,
    input  fmt_e   fmt_i,
    output logic   bclk_o,
    output logic   rise_o,
    output logic   fall_o
);
    typedef struct packed {
        logic [DIV_W-1:0] phase;
        logic             lvl;
        logic             rise;
        logic             fall;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [DIV_W-1:0] div_v, half_v;

    always_comb begin
        div_v  = DIV_W'(div_of(code_i, fmt_i));
        half_v = div_v >> 1;
        st_d   = st_q;
        if (!en_i) begin
            st_d = '0;
        end else if (div_v == DIV_W'(1)) begin
            st_d.phase = '0;
            st_d.lvl   = 1'b1;
            st_d.rise  = 1'b1;
            st_d.fall  = 1'b1;
        end else if (edge_i) begin
            st_d.phase = DIV_W'(1);
            st_d.lvl   = 1'b0;
            st_d.rise  = 1'b0;
            st_d.fall  = 1'b1;
        end else begin
            st_d.fall  = (st_q.phase == '0);
            st_d.rise  = (st_q.phase == half_v);
            if (st_d.fall)      st_d.lvl = 1'b0;
            else if (st_d.rise) st_d.lvl = 1'b1;
            st_d.phase = (st_q.phase == div_v - 1'b1) ? '0 : st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign bclk_o = st_q.lvl;
    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;

endmodule

// File: rtl/bclk_gen.sv
`timescale 1ns/1ps
module bclk_gen
    import bclk_gen_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 11,
    parameter int DIV_W       = 6
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       frame_clk_i,
    input  logic       fmt_lj_i,
    output logic       bclk_o,
    output logic       bclk_rise_o,
    output logic       bclk_fall_o,
    output logic [3:0] ratio_code_o,
    output logic       locked_o
);
    logic   fr_edge, fr_rise, lock_next;
    rcode_t code_next, code_q;
    fmt_e   fmt;

    assign fmt = fmt_e'(fmt_lj_i);

    bclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (frame_clk_i),
        .edge_o  (fr_edge),
        .rise_o  (fr_rise)
    );

    bclk_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rise_i      (fr_rise),
        .lock_next_o (lock_next),
        .code_next_o (code_next),
        .locked_o    (locked_o),
        .code_o      (code_q)
    );

    bclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .edge_i (fr_edge),
        .en_i   (lock_next),
        .code_i (code_next),
        .fmt_i  (fmt),
        .bclk_o (bclk_o),
        .rise_o (bclk_rise_o),
        .fall_o (bclk_fall_o)
    );

    assign ratio_code_o = code_q;

endmodule

// File: rtl/bclk_gen_chk.sv
`timescale 1ns/1ps
module bclk_gen_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       bclk_o,
    input logic       bclk_rise_o,
    input logic       bclk_fall_o,
    input logic [3:0] ratio_code_o,
    input logic       locked_o
);
    // R1 / R8: nothing leaves the block while unlocked
    a_r8_quiet_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !locked_o |-> (!bclk_o && !bclk_rise_o && !bclk_fall_o && ratio_code_o == 4'hF));

    // R2: only the ten defined codes appear while locked
    a_r2_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_o |-> ratio_code_o <= 4'd9);

    // R2: code does not move while lock holds
    a_r2_code_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && $past(locked_o)) |-> $stable(ratio_code_o));

    // R7: the first bit-clock edge after lock is a falling strobe
    a_r7_lock_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(locked_o) |-> bclk_fall_o);

    // R11: level high on every rising strobe
    a_r11_rise_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bclk_rise_o |-> bclk_o);

    // R11: level rises only together with a rising strobe
    a_r11_rose_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bclk_o) |-> bclk_rise_o);

    // R11: a lone falling strobe leaves the level low
    a_r11_fall_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bclk_fall_o && !bclk_rise_o) |-> !bclk_o);

endmodule

bind bclk_gen bclk_gen_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bclk_o       (bclk_o),
    .bclk_rise_o  (bclk_rise_o),
    .bclk_fall_o  (bclk_fall_o),
    .ratio_code_o (ratio_code_o),
    .locked_o     (locked_o)
);

// File: tb/tb_bclk_gen.sv
`timescale 1ns/1ps
module tb_bclk_gen;

    localparam int K_LOCK  = 0;
    localparam int K_CODE  = 1;
    localparam int K_FALL  = 2;  // exp=1: also check level low
    localparam int K_RISE  = 3;
    localparam int K_QUIET = 4;
    localparam int K_RCNT  = 5;  // exp<0: only restart the count

    typedef struct {
        int    when;
        int    kind;
        int    exp;
        string req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame = 1'b0;
    logic       fmt_lj = 1'b0;
    logic       bclk, brise, bfall, locked;
    logic [3:0] code;

    item_t sbq[$];
    int    cyc = 0;
    int    rcnt = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bclk_gen dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .frame_clk_i  (frame),
        .fmt_lj_i     (fmt_lj),
        .bclk_o       (bclk),
        .bclk_rise_o  (brise),
        .bclk_fall_o  (bfall),
        .ratio_code_o (code),
        .locked_o     (locked)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic push(input int when, input int kind, input int exp, input string req);
        item_t it;
        it.when = when; it.kind = kind; it.exp = exp; it.req = req;
        sbq.push_back(it);
    endtask

    // monitor: pops scoreboard items on their cycle, then counts rise strobes
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].when <= cyc) begin
            item_t it;
            it = sbq.pop_front();
            case (it.kind)
                K_LOCK:  check(locked == it.exp[0], it.req, int'(locked), it.exp);
                K_CODE:  check(int'(code) == it.exp, it.req, int'(code), it.exp);
                K_FALL:  check(bfall && (it.exp == 0 || !bclk), it.req,
                               int'({bfall, bclk}), it.exp ? 2 : 3);
                K_RISE:  check(brise && bclk, it.req, int'({brise, bclk}), 3);
                K_QUIET: check(!bclk && !brise && !bfall, it.req,
                               int'({bclk, brise, bfall}), 0);
                default: begin
                    if (it.exp >= 0) check(rcnt == it.exp, it.req, rcnt, it.exp);
                    rcnt = 0;
                end
            endcase
        end
        rcnt += int'(brise);
    end

    // one frame: high for half cycles, then low for half cycles
    task automatic drive_frame(input int half, input bit lk, input int ecode,
                               input int div, input int cnt, input string req);
        int t;
        @(negedge clk);
        frame = 1'b1;
        t = cyc;
        push(t + 3, K_RCNT, cnt, req);
        push(t + 3, K_LOCK, int'(lk), req);
        if (lk) begin
            push(t + 3, K_CODE, ecode, req);
            push(t + 3, K_FALL, (div > 1) ? 1 : 0, {req, "/R7"});
            push(t + 3 + div / 2, K_RISE, 1, {req, "/R11"});
        end else begin
            push(t + 3, K_QUIET, 0, req);
        end
        repeat (half) @(negedge clk);
        frame = 1'b0;
        t = cyc;
        if (lk) begin
            push(t + 3, K_FALL, (div > 1) ? 1 : 0, "R7");
            push(t + 3 + div / 2, K_RISE, 1, "R11");
        end else begin
            push(t + 3, K_QUIET, 0, req);
        end
        repeat (half - 1) @(negedge clk);
    endtask

    task automatic do_reset(input bit lj);
        @(negedge clk);
        rst_n = 1'b0;
        frame = 1'b0;
        fmt_lj = lj;
        repeat (3) @(negedge clk);
        sbq.delete();
        rst_n = 1'b1;
    endtask

    task automatic drain();
        repeat (24) @(negedge clk);
    endtask

    // full lock sequence at a steady ratio
    task automatic run_ratio(input int ratio, input bit lj, input int ecode,
                             input int bpf, input int nfr, input string req);
        int div;
        div = ratio / bpf;
        do_reset(lj);
        drive_frame(ratio / 2, 1'b0, 15, div, -1, "R2");
        drive_frame(ratio / 2, 1'b0, 15, div, 0, "R2");
        drive_frame(ratio / 2, 1'b1, ecode, div, 0, "R2");
        for (int i = 3; i < nfr; i++) drive_frame(ratio / 2, 1'b1, ecode, div, bpf, req);
        drain();
    endtask

    initial begin
        // R1: reset state
        do_reset(1'b0);
        @(negedge clk);
        check(!locked, "R1", int'(locked), 0);
        check(code == 4'hF, "R1", int'(code), 15);
        check(!bclk && !brise && !bfall, "R1", int'({bclk, brise, bfall}), 0);

        run_ratio(64,   1'b0, 0, 32, 6, "R5");
        run_ratio(64,   1'b1, 0, 64, 6, "R6");
        run_ratio(96,   1'b0, 1, 48, 5, "R3");
        run_ratio(192,  1'b1, 3, 48, 5, "R3");
        run_ratio(768,  1'b0, 7, 48, 5, "R3");
        run_ratio(1152, 1'b1, 9, 72, 5, "R4");
        run_ratio(1152, 1'b0, 9, 72, 5, "R4");
        run_ratio(1024, 1'b0, 8, 32, 5, "R5");
        run_ratio(128,  1'b0, 2, 32, 5, "R5");
        run_ratio(256,  1'b1, 4, 64, 5, "R6");
        run_ratio(512,  1'b1, 6, 64, 5, "R6");
        run_ratio(384,  1'b1, 5, 48, 5, "R3");

        // R8: unsupported period never locks
        do_reset(1'b0);
        drive_frame(50, 1'b0, 15, 1, -1, "R8");
        for (int i = 1; i < 6; i++) drive_frame(50, 1'b0, 15, 1, 0, "R8");
        drain();

        // R8: unsupported period after lock clears it
        do_reset(1'b0);
        drive_frame(64, 1'b0, 15, 4, -1, "R2");
        drive_frame(64, 1'b0, 15, 4, 0, "R2");
        drive_frame(64, 1'b1, 2, 4, 0, "R2");
        drive_frame(64, 1'b1, 2, 4, 32, "R5");
        drive_frame(50, 1'b1, 2, 4, 32, "R8");
        drive_frame(50, 1'b0, 15, 4, -1, "R8");
        drive_frame(50, 1'b0, 15, 4, 0, "R8");
        drain();

        // R10: ratio change 128 -> 256, I2S
        do_reset(1'b0);
        drive_frame(64, 1'b0, 15, 4, -1, "R2");
        drive_frame(64, 1'b0, 15, 4, 0, "R2");
        drive_frame(64, 1'b1, 2, 4, 0, "R2");
        drive_frame(64, 1'b1, 2, 4, 32, "R10");
        drive_frame(128, 1'b1, 2, 4, 32, "R10");
        drive_frame(128, 1'b0, 15, 8, -1, "R10");
        drive_frame(128, 1'b1, 4, 8, 0, "R10");
        drive_frame(128, 1'b1, 4, 8, 32, "R10");
        drain();

        // R9: frame clock stops after lock
        do_reset(1'b0);
        drive_frame(32, 1'b0, 15, 2, -1, "R2");
        drive_frame(32, 1'b0, 15, 2, 0, "R2");
        drive_frame(32, 1'b1, 0, 2, 0, "R2");
        drive_frame(32, 1'b1, 0, 2, 32, "R9");
        push(cyc + 1300, K_LOCK, 0, "R9");
        push(cyc + 1300, K_CODE, 15, "R9");
        push(cyc + 1300, K_QUIET, 0, "R9");
        repeat (1310) @(negedge clk);

        check(sbq.size() == 0, "SB", sbq.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule